// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is the 34-cell test data register that sits between a chip's functional core and its pads. It serves 13 bidirectional pins, 4 output-only pins and 4 input-only pins. A test access port controller, which lies outside this block, drives it with a serial input and capture, shift and update strobes. The controller also supplies a test-drive mode flag and a float-all flag. The block returns one serial output.

In capture, every cell records what is currently at its pin, or the enable state of its pin's driver. Shift moves the whole image one cell toward the serial output on each rising test clock edge. Update copies the shifted image into a separate hold stage on the falling edge.

When the test-drive mode flag is high, the pads take their values and output enables from the hold stage. When the flag is low, the core owns the pads, so sampling or preloading never disturbs normal operation. The core-side copies of incoming pad values always follow the pads. The float-all flag turns off every bidirectional driver.

Top module: `bscan_chain`

## Requirements
- R1: An active-low `rstN` puts the hold stage in its safe image: every control cell holds 1 and every data cell holds 0. With `extestMode` high, every bidirectional enable is then low and every output pin is low.
- R2: With `extestMode` low, `padBiOut`, `padBiOe` and `padOut` equal the core-side values `coreBiOut`, `coreBiOe` and `coreOut`.
- R3: On a rising `tck` with `captureDr` high, each bidirectional data cell loads `padBiIn` and each output-only cell loads the value being driven on `padOut`. Each input-only cell loads `padIn`. Capture takes priority over shift.
- R4: On a rising `tck` with `shiftDr` high, the chain moves one cell toward cell 0. `scanIn` enters cell 33 and `scanOut` shows cell 0, so 34 shifts carry a full image through the chain.
- R5: The cell layout is fixed. Bidirectional pins 0 to 7 have their data cells at 32, 30, 28, 26, 24, 22, 20 and 18, pins 8 to 10 at 11, 9 and 7, and pins 11 and 12 at 4 and 2. Each pin's control cell sits one index above its data cell. Output pins 0, 1 and 2 are at cells 17, 16 and 15, and output pin 3 is at cell 0. Input pins 0 and 1 are at cells 14 and 13, input pin 2 at cell 6 and input pin 3 at cell 1.
- R6: On a falling `tck` with `updateDr` high, the hold stage copies the chain. With `extestMode` high, each output and bidirectional pin then drives its data cell's value. A control cell holding 1 turns its pin's enable off, and 0 turns it on.
- R7: With `extestMode` low, shifting and updating leave every pad output and enable at the core's values.
- R8: The hold stage changes only on an update strobe. Shifting under `extestMode` leaves the pads unchanged.
- R9: `floatAll` forces every `padBiOe` bit low in both modes, and `padOut` keeps its value.
- R10: A control cell captures the inverse of its pin's `coreBiOe`, which is 1 when the core is not driving the pin.
- R11: `coreBiIn` and `coreIn` follow `padBiIn` and `padIn` in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scanIn | input | 1 | Serial data into cell 33 |
| scanOut | output | 1 | Serial data from cell 0 |
| captureDr | input | 1 | Capture strobe |
| shiftDr | input | 1 | Shift strobe |
| updateDr | input | 1 | Update strobe, acts on falling edge |
| extestMode | input | 1 | Pads driven from hold stage |
| floatAll | input | 1 | Disable every bidirectional driver |
| coreBiOut | input | 13 | Core output value per bidirectional pin |
| coreBiOe | input | 13 | Core output enable per bidirectional pin, 1 = drive |
| coreBiIn | output | 13 | Pad value returned to core |
| padBiOut | output | 13 | Value toward bidirectional pad driver |
| padBiOe | output | 13 | Enable toward bidirectional pad driver, 1 = drive |
| padBiIn | input | 13 | Value seen at bidirectional pad |
| coreOut | input | 4 | Core value per output-only pin |
| padOut | output | 4 | Value toward output-only pad |
| padIn | input | 4 | Value at input-only pad |
| coreIn | output | 4 | Input-only pad value returned to core |

## Verification
Two functions can act in the same cycle: the float-all override and the hold-stage drive under test-drive mode. Both claim the bidirectional enables. The bench preloads images whose control cells hold 0, so the hold stage asks to drive. It then raises the float flag with test-drive mode on and judges that every enable drops while the output pins keep the preloaded values. It also checks that the enables return once the flag falls. A second overlap, shifting while the hold stage drives the pads, is provoked by shifting a new image under test-drive mode; the pads must hold the old image until the update strobe.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  localparam int NumBidir = 13;
  localparam int NumOut   = 4;
  localparam int NumIn    = 4;
  localparam int ChainLen = 2 * NumBidir + NumOut + NumIn;
  localparam int IdxW     = $clog2(ChainLen);

  typedef enum logic [1:0] {
    KindCtl   = 2'd0,
    KindBidir = 2'd1,
    KindOut   = 2'd2,
    KindIn    = 2'd3
  } cellKind_e;

  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
    logic extest;
    logic floatAll;
  } scanStrobe_t;

  // Cell role by chain index (33 nearest the serial input, 0 nearest the output)
  function automatic cellKind_e kindOf(int idx);
    if (idx >= 18)                 return (idx % 2 == 1) ? KindCtl : KindBidir;
    else if (idx >= 15)            return KindOut;
    else if (idx >= 13)            return KindIn;
    else if (idx >= 7)             return (idx % 2 == 0) ? KindCtl : KindBidir;
    else if (idx == 6 || idx == 1) return KindIn;
    else if (idx >= 2)             return (idx % 2 == 1) ? KindCtl : KindBidir;
    else                           return KindOut;
  endfunction

  // Pin number served by a cell, within its pin class
  function automatic int pinOf(int idx);
    if (idx >= 18)      return (idx % 2 == 1) ? (33 - idx) / 2 : (32 - idx) / 2;
    else if (idx >= 15) return 17 - idx;
    else if (idx >= 13) return 14 - idx;
    else if (idx >= 7)  return (idx % 2 == 0) ? 8 + (12 - idx) / 2 : 8 + (11 - idx) / 2;
    else if (idx == 6)  return 2;
    else if (idx == 1)  return 3;
    else if (idx >= 2)  return (idx % 2 == 1) ? 11 + (5 - idx) / 2 : 11 + (4 - idx) / 2;
    else                return 3;
  endfunction

  function automatic int bidirDataIdx(int pin);
    if (pin < 8)       return 32 - 2 * pin;
    else if (pin < 11) return 11 - 2 * (pin - 8);
    else               return 4 - 2 * (pin - 11);
  endfunction

  function automatic int outCellIdx(int pin);
    return (pin < 3) ? 17 - pin : 0;
  endfunction

endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic        captureDr,
  input  logic        shiftDr,
  input  logic        updateDr,
  input  logic        extestMode,
  input  logic        floatAll,
  output scanStrobe_t strobe
);

  // Capture wins over shift; update only when the chain is idle.
  always_comb begin
    strobe.capture  = captureDr;
    strobe.shift    = shiftDr & ~captureDr;
    strobe.update   = updateDr & ~captureDr & ~shiftDr;
    strobe.extest   = extestMode;
    strobe.floatAll = floatAll;
  end

endmodule

// File: rtl/bscan_cells.sv
module bscan_cells
  import bscan_pkg::*;
(
  input  logic                tck,
  input  logic                rstN,
  input  scanStrobe_t         strobe,
  input  logic                scanIn,
  output logic                scanOut,
  input  logic [NumBidir-1:0] coreBiOut,
  input  logic [NumBidir-1:0] coreBiOe,
  output logic [NumBidir-1:0] coreBiIn,
  output logic [NumBidir-1:0] padBiOut,
  output logic [NumBidir-1:0] padBiOe,
  input  logic [NumBidir-1:0] padBiIn,
  input  logic [NumOut-1:0]   coreOut,
  output logic [NumOut-1:0]   padOut,
  input  logic [NumIn-1:0]    padIn,
  output logic [NumIn-1:0]    coreIn
);

  logic [ChainLen-1:0] shiftReg;
  logic [ChainLen-1:0] capVec;
  logic [NumBidir-1:0] updData;
  logic [NumBidir-1:0] updCtl;
  logic [NumOut-1:0]   updOut;

  // Capture sources, one per cell, chosen by the fixed layout
  for (genvar c = 0; c < ChainLen; c++) begin : g_cap
    localparam cellKind_e Kind = kindOf(c);
    localparam int        Pin  = pinOf(c);
    if (Kind == KindCtl) begin : g_ctl
      assign capVec[c] = ~coreBiOe[Pin];
    end else if (Kind == KindBidir) begin : g_bi
      assign capVec[c] = padBiIn[Pin];
    end else if (Kind == KindOut) begin : g_out
      assign capVec[c] = padOut[Pin];
    end else begin : g_in
      assign capVec[c] = padIn[Pin];
    end
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (strobe.capture) shiftReg <= capVec;
    else if (strobe.shift)   shiftReg <= {scanIn, shiftReg[ChainLen-1:1]};
  end

  assign scanOut = shiftReg[0];

  // Hold stage and pad multiplexing for bidirectional pins
  for (genvar p = 0; p < NumBidir; p++) begin : g_bidir
    localparam int DataIdx = bidirDataIdx(p);
    localparam int CtlIdx  = DataIdx + 1;

    always_ff @(negedge tck or negedge rstN) begin
      if (!rstN) begin
        updData[p] <= 1'b0;
        updCtl[p]  <= 1'b1;
      end else if (strobe.update) begin
        updData[p] <= shiftReg[DataIdx];
        updCtl[p]  <= shiftReg[CtlIdx];
      end
    end

    assign padBiOut[p] = strobe.extest ? updData[p] : coreBiOut[p];
    assign padBiOe[p]  = ~strobe.floatAll & (strobe.extest ? ~updCtl[p] : coreBiOe[p]);
  end

  // Hold stage and pad multiplexing for output-only pins
  for (genvar q = 0; q < NumOut; q++) begin : g_out
    localparam int CellIdx = outCellIdx(q);

    always_ff @(negedge tck or negedge rstN) begin
      if (!rstN)              updOut[q] <= 1'b0;
      else if (strobe.update) updOut[q] <= shiftReg[CellIdx];
    end

    assign padOut[q] = strobe.extest ? updOut[q] : coreOut[q];
  end

  assign coreBiIn = padBiIn;
  assign coreIn   = padIn;

  // Shift moves the image one cell toward the serial output
  p_shift_moves_r4: assert property (@(posedge tck) disable iff (!rstN)
    strobe.shift |=> shiftReg[ChainLen-2:0] == $past(shiftReg[ChainLen-1:1]));

  // Capture and shift never both act
  p_cap_excl_r3: assert property (@(posedge tck) disable iff (!rstN)
    $onehot0({strobe.capture, strobe.shift}));

  // Hold stage only moves on an update strobe
  p_hold_stable_r8: assert property (@(negedge tck) disable iff (!rstN)
    !strobe.update |=> $stable({updData, updCtl, updOut}));

  // Float-all keeps every bidirectional driver off
  p_float_off_r9: assert property (@(posedge tck) disable iff (!rstN)
    strobe.floatAll |-> padBiOe == '0);

  // Functional mode: output-only pins belong to the core
  p_core_owns_r7: assert property (@(posedge tck) disable iff (!rstN)
    !strobe.extest |-> padOut == coreOut);

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
(
  input  logic                tck,
  input  logic                rstN,
  input  logic                scanIn,
  output logic                scanOut,
  input  logic                captureDr,
  input  logic                shiftDr,
  input  logic                updateDr,
  input  logic                extestMode,
  input  logic                floatAll,
  input  logic [NumBidir-1:0] coreBiOut,
  input  logic [NumBidir-1:0] coreBiOe,
  output logic [NumBidir-1:0] coreBiIn,
  output logic [NumBidir-1:0] padBiOut,
  output logic [NumBidir-1:0] padBiOe,
  input  logic [NumBidir-1:0] padBiIn,
  input  logic [NumOut-1:0]   coreOut,
  output logic [NumOut-1:0]   padOut,
  input  logic [NumIn-1:0]    padIn,
  output logic [NumIn-1:0]    coreIn
);

  scanStrobe_t strobe;

  bscan_ctrl i_ctrl (
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .extestMode(extestMode),
    .floatAll  (floatAll),
    .strobe    (strobe)
  );

  bscan_cells i_cells (
    .tck      (tck),
    .rstN     (rstN),
    .strobe   (strobe),
    .scanIn   (scanIn),
    .scanOut  (scanOut),
    .coreBiOut(coreBiOut),
    .coreBiOe (coreBiOe),
    .coreBiIn (coreBiIn),
    .padBiOut (padBiOut),
    .padBiOe  (padBiOe),
    .padBiIn  (padBiIn),
    .coreOut  (coreOut),
    .padOut   (padOut),
    .padIn    (padIn),
    .coreIn   (coreIn)
  );

endmodule

// File: tb/test_bscan_chain.sv
module test_bscan_chain;

  logic        tck = 1'b0;
  logic        rstN;
  logic        scanIn, scanOut;
  logic        captureDr, shiftDr, updateDr, extestMode, floatAll;
  logic [12:0] coreBiOut, coreBiOe, coreBiIn, padBiOut, padBiOe, padBiIn;
  logic [3:0]  coreOut, padOut, padIn, coreIn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 tck = ~tck;

  bscan_chain i_bscan_chain (
    .tck(tck), .rstN(rstN), .scanIn(scanIn), .scanOut(scanOut),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .extestMode(extestMode), .floatAll(floatAll),
    .coreBiOut(coreBiOut), .coreBiOe(coreBiOe), .coreBiIn(coreBiIn),
    .padBiOut(padBiOut), .padBiOe(padBiOe), .padBiIn(padBiIn),
    .coreOut(coreOut), .padOut(padOut), .padIn(padIn), .coreIn(coreIn)
  );

  // Layout from R5, written as explicit tables
  function automatic int dIdx(int p);
    case (p)
      0: return 32;  1: return 30;  2: return 28;  3: return 26;
      4: return 24;  5: return 22;  6: return 20;  7: return 18;
      8: return 11;  9: return 9;   10: return 7;  11: return 4;
      default: return 2;
    endcase
  endfunction

  function automatic int oIdx(int q);
    case (q) 0: return 17; 1: return 16; 2: return 15; default: return 0; endcase
  endfunction

  function automatic int iIdx(int q);
    case (q) 0: return 14; 1: return 13; 2: return 6; default: return 1; endcase
  endfunction

  // Expected capture image (R3, R10)
  function automatic logic [33:0] expCap(input logic [12:0] oe, input logic [12:0] bi,
                                         input logic [3:0] po, input logic [3:0] pi);
    logic [33:0] v = '0;
    for (int p = 0; p < 13; p++) begin
      v[dIdx(p)]     = bi[p];
      v[dIdx(p) + 1] = ~oe[p];
    end
    for (int q = 0; q < 4; q++) begin
      v[oIdx(q)] = po[q];
      v[iIdx(q)] = pi[q];
    end
    return v;
  endfunction

  function automatic logic [12:0] expBiOut(input logic [33:0] v);
    logic [12:0] r;
    for (int p = 0; p < 13; p++) r[p] = v[dIdx(p)];
    return r;
  endfunction

  function automatic logic [12:0] expBiOe(input logic [33:0] v, input logic fl);
    logic [12:0] r;
    for (int p = 0; p < 13; p++) r[p] = ~v[dIdx(p) + 1] & ~fl;
    return r;
  endfunction

  function automatic logic [3:0] expOut(input logic [33:0] v);
    logic [3:0] r;
    for (int q = 0; q < 4; q++) r[q] = v[oIdx(q)];
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic randomPins();
    coreBiOut = 13'($urandom);
    coreBiOe  = 13'($urandom);
    padBiIn   = 13'($urandom);
    coreOut   = 4'($urandom);
    padIn     = 4'($urandom);
  endtask

  // All tasks start and end 2 ns after a rising edge
  task automatic doCapture();
    captureDr = 1'b1;
    @(posedge tck); #2;
    captureDr = 1'b0;
  endtask

  task automatic doUpdate();
    updateDr = 1'b1;
    @(posedge tck); #2;
    updateDr = 1'b0;
  endtask

  task automatic shiftVec(input logic [33:0] vin, output logic [33:0] vout);
    for (int i = 0; i < 34; i++) begin
      scanIn  = vin[i];
      shiftDr = 1'b1;
      vout[i] = scanOut;
      @(posedge tck); #2;
    end
    shiftDr = 1'b0;
  endtask

  task automatic checkExtest(input string tag, input logic [33:0] v);
    #1;
    check({tag, " padBiOut"}, 64'(padBiOut), 64'(expBiOut(v)));
    check({tag, " padBiOe"},  64'(padBiOe),  64'(expBiOe(v, floatAll)));
    check({tag, " padOut"},   64'(padOut),   64'(expOut(v)));
  endtask

  task automatic checkFunctional(input string tag);
    #1;
    check({tag, " padBiOut"}, 64'(padBiOut), 64'(coreBiOut));
    check({tag, " padBiOe"},  64'(padBiOe),  64'(coreBiOe & {13{~floatAll}}));
    check({tag, " padOut"},   64'(padOut),   64'(coreOut));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [33:0] got, vA, vB, vC, cap;
    int unsigned seedVal;
    seedVal = $urandom(32'd4711);

    rstN = 1'b0; scanIn = 1'b0; captureDr = 1'b0; shiftDr = 1'b0; updateDr = 1'b0;
    extestMode = 1'b1; floatAll = 1'b0;
    coreBiOut = '1; coreBiOe = '1; padBiIn = '0; coreOut = '1; padIn = '0;
    repeat (3) @(posedge tck);
    #2 rstN = 1'b1;
    @(posedge tck); #2;

    // R1: safe image after reset, test-drive mode on
    #1;
    check("R1 padBiOe", 64'(padBiOe), 64'(0));
    check("R1 padOut",  64'(padOut),  64'(0));
    check("R1 padBiOut", 64'(padBiOut), 64'(0));

    // R2 / R11: functional pass-through, random patterns
    extestMode = 1'b0;
    for (int k = 0; k < 20; k++) begin
      randomPins();
      checkFunctional("R2");
      check("R11 coreBiIn", 64'(coreBiIn), 64'(padBiIn));
      check("R11 coreIn",   64'(coreIn),   64'(padIn));
      @(posedge tck); #2;
    end

    // R3 / R10 / R5: capture then shift out, random patterns and corners
    for (int k = 0; k < 8; k++) begin
      randomPins();
      if (k == 0) begin coreBiOe = '0; padBiIn = '1; coreOut = '1; padIn = '1; end
      if (k == 1) begin coreBiOe = '1; padBiIn = '0; coreOut = '0; padIn = '0; end
      cap = expCap(coreBiOe, padBiIn, coreOut, padIn);
      doCapture();
      shiftVec(34'($urandom) ^ {2'b0, 32'($urandom)}, got);
      check("R3 R5 R10 capture image", 64'(got), 64'(cap));
    end

    // R7: preload under functional mode leaves pads with the core
    vA = {2'($urandom), 32'($urandom)};
    vA[dIdx(0) + 1] = 1'b0;
    randomPins();
    shiftVec(vA, got);
    checkFunctional("R7 after shift");
    doUpdate();
    checkFunctional("R7 after update");

    // R6 / R5: test-drive mode takes the preloaded image
    extestMode = 1'b1;
    checkExtest("R6", vA);
    randomPins();
    #1;
    check("R11 extest coreBiIn", 64'(coreBiIn), 64'(padBiIn));
    check("R11 extest coreIn",   64'(coreIn),   64'(padIn));

    // R8 / R4: shift a new image under test-drive; pads hold, old image emerges
    vB = {2'($urandom), 32'($urandom)};
    shiftVec(vB, got);
    check("R4 chain length 34", 64'(got), 64'(vA));
    checkExtest("R8 hold while shifting", vA);
    doUpdate();
    checkExtest("R6 second image", vB);

    // R9: float-all overlapping the hold-stage drive (all controls enable)
    vC = {2'($urandom), 32'($urandom)};
    for (int p = 0; p < 13; p++) vC[dIdx(p) + 1] = 1'b0;
    shiftVec(vC, got);
    doUpdate();
    checkExtest("R6 all enabled", vC);
    floatAll = 1'b1;
    checkExtest("R9 float under extest", vC);
    check("R9 all off", 64'(padBiOe), 64'(0));
    floatAll = 1'b0;
    checkExtest("R9 float released", vC);

    // R1 corner: all-ones image disables every driver
    shiftVec('1, got);
    check("R4 shifted out previous", 64'(got), 64'(vC));
    doUpdate();
    checkExtest("R6 all ones", '1);

    // R9 in functional mode
    extestMode = 1'b0;
    coreBiOe = '1;
    floatAll = 1'b1;
    checkFunctional("R9 functional float");
    floatAll = 1'b0;

    // R3: output-only cells capture the driven pad value under test-drive
    extestMode = 1'b1;
    randomPins();
    cap = expCap(coreBiOe, padBiIn, 4'hF, padIn);
    doCapture();
    shiftVec('0, got);
    check("R3 capture under extest", 64'(got), 64'(cap));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule